// File: doc/BRIEF.md
# Storage Card Host Bus Decoder

This block is the card-side front end of a removable flash storage card. It watches the host's address lines, the two active-low card enables, the attribute select and the four read/write strobes. From these it decides which space and register an access targets, whether the access is a byte or a word, and which byte lane carries each byte. It holds an eight-register task file, a 16-bit data register, a device control register, a small attribute memory and a configuration register. The media controller, command execution and the sector buffer behind the data register are handled elsewhere.

The card has three personalities. In memory mode the output and write strobes reach attribute space and a memory-mapped copy of the task file. In I/O mode, which is entered by writing the configuration register, the I/O strobes reach the task file. In IDE mode, which is chosen by holding the output-enable input low while reset is asserted, only the low three address bits are decoded and each card enable picks its own register group. Host strobes are asynchronous, so they pass through two flip-flops before use. Writes take effect on the trailing (rising) edge of a strobe.

Top module: `card_bus_front`

## Requirements
- R1: Reset clears every register, including the attribute bytes, the task file and the configuration register. After release, reads return zero, I/O mode is off, `dout_en` is low and `word16_n` is high.
- R2: In memory mode, when both enables are low and `reg_n` is high, the access is a word into common memory. The even byte (A0 forced 0) is on D[7:0] and the odd byte on D[15:8]. Common memory decodes A[3:0]: 0-7 are task file bytes, 0xE reads task register 7 and writes device control, 0xF reads device control back, and other offsets are unmapped. A word at offsets 0/1 carries the 16-bit data register, whose low byte is task register 0.
- R3: With only the first enable low, the byte at the address (A0 picks even or odd) is on D[7:0] and D[15:8] reads 0xFF. With only the second enable low, the odd byte of the addressed word is on D[15:8] and D[7:0] reads 0xFF.
- R4: IDE mode is latched from `oe_n` low during reset and is held until the next reset. The first enable selects task register A[2:0] on D[7:0], and A[10:3] are ignored. Register 0 moves all 16 bits of the data register. With the second enable, offset 6 reads register 7 and writes device control, offset 7 reads device control, and other offsets read 0xFFFF. `oe_n` and `we_n` are ignored.
- R5: With `reg_n` low, the output/write strobes reach attribute space. Only even byte addresses below twice `ATTR_WORDS` hold data. Odd bytes read 0xFF, so a word read has D[15:8]=0xFF, and writes to odd bytes are dropped.
- R6: A write stores the data and address present at the strobe's rising edge. Data held during the low phase is not stored.
- R7: In memory mode, `iord_n` drives nothing and `iowr_n` changes no register.
- R8: Attribute byte 0x200 is the configuration register. Any nonzero value in its bits [5:0] selects I/O mode. In I/O mode the task file map of R2 is reached by `iord_n`/`iowr_n` with `reg_n` low, and `oe_n` with `reg_n` high no longer answers.
- R9: `word16_n` is low in IDE mode when the first enable alone selects offset 0. In I/O mode it is low when `reg_n` and the first enable are low and A[3:1]=0. It is high in every other case.
- R10: `dout_en` is low unless a decoded read is in progress. Reads of unmapped addresses return 0xFF in each byte.
- R11: `dout_en` rises at the second clock edge after a read strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset; clears all registers, mode sampled while low |
| addr | input | ADDR_W | Host address lines |
| ce1_n | input | 1 | First card enable, active low |
| ce2_n | input | 1 | Second card enable, active low (odd byte) |
| reg_n | input | 1 | Low selects attribute space / I/O cycle |
| oe_n | input | 1 | Output strobe; low during reset selects IDE mode |
| we_n | input | 1 | Write strobe for attribute/common memory |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| din | input | 16 | Host write data |
| dout | output | 16 | Read data, zero when not driven |
| dout_en | output | 1 | High while the card drives the data bus |
| word16_n | output | 1 | Low when a 16-bit data register transfer is expected |

## Verification
The assertions assume that the host holds the address, the enables, `reg_n` and the write data steady from before a strobe falls until at least three clocks after it rises. They also assume that no more than one strobe is low at a time, and that every strobe level lasts several clocks, so the synchronizers see each edge. The bench drives each access through one task that sets the address and enables, opens the strobe for four clocks, closes it, and holds everything for four more clocks. The mid-strobe data change used for R6 alters only the data and keeps it steady across the rising edge.

// File: rtl/card_bus_front.sv
module card_bus_front #(
  parameter int ADDR_W     = 11,
  parameter int ATTR_WORDS = 16,
  parameter int CFG_BYTE   = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              reg_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic              dout_en,
  output logic              word16_n
);
  localparam int AIX_W = (ATTR_WORDS > 1) ? $clog2(ATTR_WORDS) : 1;
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BYTE);

  logic [3:0] s1, s2, s3;
  logic       ide_q, io_q;
  logic [7:0] attr_q [ATTR_WORDS];
  logic [7:0] tf_q [8];
  logic [7:0] cfg_q, dhi_q, dev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
    end else begin
      s1 <= {iowr_n, iord_n, we_n, oe_n};
      s2 <= s1;
      s3 <= s2;
    end

  always_ff @(posedge clk)
    if (!rst_n) ide_q <= ~oe_n;

  assign io_q = |cfg_q[5:0];

  logic mem_rd, mem_wev, io_rd, io_wev, any_ce;
  assign mem_rd  = ~s2[0];
  assign mem_wev = s2[1] & ~s3[1];
  assign io_rd   = ~s2[2];
  assign io_wev  = s2[3] & ~s3[3];
  assign any_ce  = ~(ce1_n & ce2_n);

  logic attr_sel, cmn_sel, iot_sel, ide_cs;
  assign attr_sel = ~ide_q & ~reg_n;
  assign cmn_sel  = ~ide_q & ~io_q & reg_n;
  assign iot_sel  = ~ide_q & io_q & ~reg_n;
  assign ide_cs   = ide_q & (ce1_n ^ ce2_n);

  logic rd_attr, rd_tf, rd_ide, wr_attr, wr_tf, wr_ide;
  assign rd_attr = mem_rd & attr_sel & any_ce;
  assign rd_tf   = ((mem_rd & cmn_sel) | (io_rd & iot_sel)) & any_ce;
  assign rd_ide  = io_rd & ide_cs;
  assign wr_attr = mem_wev & attr_sel & any_ce;
  assign wr_tf   = ((mem_wev & cmn_sel) | (io_wev & iot_sel)) & any_ce;
  assign wr_ide  = io_wev & ide_cs;

  logic [ADDR_W-1:0] lo_a, hi_a, lo_wa;
  assign lo_a  = {addr[ADDR_W-1:1], 1'b0};
  assign hi_a  = {addr[ADDR_W-1:1], 1'b1};
  assign lo_wa = ce2_n ? addr : lo_a;

  function automatic logic [7:0] space_byte(input logic to_tf, input logic [ADDR_W-1:0] a);
    if (to_tf) begin
      if (!a[3])              return tf_q[a[2:0]];
      else if (a[3:0] == 4'hE) return tf_q[7];
      else if (a[3:0] == 4'hF) return dev_q;
      else                     return 8'hFF;
    end else begin
      if (!a[0] && int'(a[ADDR_W-1:1]) < ATTR_WORDS) return attr_q[a[AIX_W:1]];
      else if (a == CFG_A)                            return cfg_q;
      else                                            return 8'hFF;
    end
  endfunction

  logic [15:0] rd_word;
  always_comb begin
    rd_word = 16'hFFFF;
    if (rd_ide) begin
      if (!ce1_n)
        rd_word = (addr[2:0] == 3'd0) ? {dhi_q, tf_q[0]} : {8'hFF, tf_q[addr[2:0]]};
      else if (addr[2:0] == 3'd6)
        rd_word = {8'hFF, tf_q[7]};
      else if (addr[2:0] == 3'd7)
        rd_word = {8'hFF, dev_q};
    end else if (rd_attr | rd_tf) begin
      case ({ce2_n, ce1_n})
        2'b00:   rd_word = (rd_tf && lo_a[3:0] == 4'd0) ? {dhi_q, tf_q[0]}
                         : {space_byte(rd_tf, hi_a), space_byte(rd_tf, lo_a)};
        2'b10:   rd_word = {8'hFF, space_byte(rd_tf, addr)};
        2'b01:   rd_word = {space_byte(rd_tf, hi_a), 8'hFF};
        default: rd_word = 16'hFFFF;
      endcase
    end
  end

  assign dout_en = rd_ide | rd_attr | rd_tf;
  assign dout    = dout_en ? rd_word : 16'h0000;

  assign word16_n = ~((ide_q & ~ce1_n & ce2_n & (addr[2:0] == 3'd0)) |
                      (~ide_q & io_q & ~reg_n & ~ce1_n & (addr[3:1] == 3'd0)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ATTR_WORDS; i++) attr_q[i] <= '0;
      for (int j = 0; j < 8; j++) tf_q[j] <= '0;
      cfg_q <= '0;
      dhi_q <= '0;
      dev_q <= '0;
    end else begin
      if (wr_attr && !ce1_n) begin
        for (int i = 0; i < ATTR_WORDS; i++)
          if (!lo_wa[0] && lo_wa[ADDR_W-1:1] == (ADDR_W-1)'(i)) attr_q[i] <= din[7:0];
        if (lo_wa == CFG_A) cfg_q <= din[7:0];
      end
      if (wr_tf) begin
        if (!ce1_n && !ce2_n && lo_a[3:0] == 4'd0) begin
          tf_q[0] <= din[7:0];
          dhi_q   <= din[15:8];
        end else begin
          for (int j = 0; j < 8; j++)
            if (!ce1_n && lo_wa[3:0] == 4'(j)) tf_q[j] <= din[7:0];
            else if (!ce2_n && hi_a[3:0] == 4'(j)) tf_q[j] <= din[15:8];
          if (!ce1_n && lo_wa[3:0] == 4'hE) dev_q <= din[7:0];
        end
      end
      if (wr_ide) begin
        if (!ce1_n) begin
          for (int j = 0; j < 8; j++)
            if (addr[2:0] == 3'(j)) tf_q[j] <= din[7:0];
          if (addr[2:0] == 3'd0) dhi_q <= din[15:8];
        end else if (addr[2:0] == 3'd6) begin
          dev_q <= din[7:0];
        end
      end
    end
endmodule

// File: rtl/card_bus_front_chk.sv
module card_bus_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        iord_n,
  input logic        iowr_n,
  input logic        ce1_n,
  input logic        ce2_n,
  input logic        reg_n,
  input logic [15:0] dout,
  input logic        dout_en,
  input logic        word16_n,
  input logic        ide_q,
  input logic        io_q,
  input logic [7:0]  tf0
);
  assert_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe_n, 2) && $past(iord_n, 2)) |-> !dout_en);

  assert_ide_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ide_q));

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !ide_q && !ce1_n && ce2_n) |-> dout[15:8] == 8'hFF);

  assert_attr_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !ide_q && !io_q && !reg_n) |-> dout[15:8] == 8'hFF);

  assert_io_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_q && !io_q && $past(oe_n, 2)) |-> !dout_en);

  assert_word16_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_q && !io_q) |-> word16_n);

  assert_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tf0) |-> ($past(we_n, 3) && $past(iowr_n, 3)));
endmodule

bind card_bus_front card_bus_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n),
  .iowr_n(iowr_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
  .dout(dout), .dout_en(dout_en), .word16_n(word16_n),
  .ide_q(ide_q), .io_q(io_q), .tf0(tf_q[0])
);

// File: tb/card_bus_front_test.sv
module card_bus_front_test;
  localparam int AW = 16;
  localparam int S_OE = 0, S_WE = 1, S_RD = 2, S_WR = 3;

  logic clk = 0, rst_n = 0;
  logic [10:0] addr = '0;
  logic ce1_n = 1, ce2_n = 1, reg_n = 1, oe_n = 1, we_n = 1, iord_n = 1, iowr_n = 1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic dout_en, word16_n;

  always #5 clk = ~clk;

  card_bus_front uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .din(din), .dout(dout), .dout_en(dout_en), .word16_n(word16_n)
  );

  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] m_attr [AW];
  logic [7:0] m_tf [8];
  logic [7:0] m_cfg, m_dhi, m_dev;
  bit m_ide;
  bit [3:0] ms1, ms2, ms3;

  function automatic logic [7:0] mbyte(bit tsk, int a);
    if (!tsk) begin
      if (a % 2 == 0 && a / 2 < AW) return m_attr[a / 2];
      if (a == 512) return m_cfg;
      return 8'hFF;
    end
    if (a % 16 < 8) return m_tf[a % 16];
    if (a % 16 == 14) return m_tf[7];
    if (a % 16 == 15) return m_dev;
    return 8'hFF;
  endfunction

  function automatic void m_put(bit tsk, int a, logic [7:0] v);
    if (!tsk) begin
      if (a % 2 == 0 && a / 2 < AW) m_attr[a / 2] = v;
      else if (a == 512) m_cfg = v;
    end else if (a % 16 < 8) m_tf[a % 16] = v;
    else if (a % 16 == 14) m_dev = v;
  endfunction

  function automatic int m_space(bit mem, bit io_s);
    bit io = (m_cfg & 8'h3F) != 0;
    if (ce1_n && ce2_n) return 0;
    if (mem && !reg_n) return 1;
    if ((mem && reg_n && !io) || (io_s && !reg_n && io)) return 2;
    return 0;
  endfunction

  function automatic void m_exp(output bit en, output logic [15:0] d);
    int a = int'(addr);
    int sp;
    en = 0; d = 16'hFFFF;
    if (m_ide) begin
      if (!ms2[2] && (ce1_n != ce2_n)) begin
        en = 1;
        if (!ce1_n) d = (a % 8 == 0) ? {m_dhi, m_tf[0]} : {8'hFF, m_tf[a % 8]};
        else if (a % 8 == 6) d = {8'hFF, m_tf[7]};
        else if (a % 8 == 7) d = {8'hFF, m_dev};
      end
    end else begin
      sp = m_space(!ms2[0], !ms2[2]);
      if (sp != 0) begin
        en = 1;
        if (!ce1_n && !ce2_n)
          d = (sp == 2 && (a & 14) == 0) ? {m_dhi, m_tf[0]}
            : {mbyte(sp == 2, a | 1), mbyte(sp == 2, a & ~1)};
        else if (!ce1_n) d = {8'hFF, mbyte(sp == 2, a)};
        else d = {mbyte(sp == 2, a | 1), 8'hFF};
      end
    end
  endfunction

  always @(posedge clk) if (!rst_n) m_ide = !oe_n;

  always @(posedge clk or negedge rst_n) begin
    int a;
    int sp;
    if (!rst_n) begin
      for (int i = 0; i < AW; i++) m_attr[i] = 0;
      for (int j = 0; j < 8; j++) m_tf[j] = 0;
      m_cfg = 0; m_dhi = 0; m_dev = 0;
      ms1 = 4'hF; ms2 = 4'hF; ms3 = 4'hF;
    end else begin
      a = int'(addr);
      if (m_ide) begin
        if (ms2[3] && !ms3[3] && ce1_n != ce2_n) begin
          if (!ce1_n) begin
            m_tf[a % 8] = din[7:0];
            if (a % 8 == 0) m_dhi = din[15:8];
          end else if (a % 8 == 6) m_dev = din[7:0];
        end
      end else begin
        sp = m_space(ms2[1] && !ms3[1], ms2[3] && !ms3[3]);
        if (sp == 2 && !ce1_n && !ce2_n && (a & 14) == 0) begin
          m_tf[0] = din[7:0];
          m_dhi = din[15:8];
        end else if (sp != 0) begin
          if (!ce1_n) m_put(sp == 2, ce2_n ? a : (a & ~1), din[7:0]);
          if (!ce2_n) m_put(sp == 2, a | 1, din[15:8]);
        end
      end
      ms3 = ms2; ms2 = ms1; ms1 = {iowr_n, iord_n, we_n, oe_n};
    end
  end

  always @(negedge clk) begin
    bit en;
    logic [15:0] d;
    bit w;
    if (rst_n && !done) begin
      m_exp(en, d);
      chk({phase, " dout_en"}, dout_en, en);
      if (en) chk({phase, " dout"}, dout, d);
      if (m_ide) w = !(!ce1_n && ce2_n && addr[2:0] == 0);
      else if ((m_cfg & 8'h3F) != 0) w = !(!reg_n && !ce1_n && addr[3:1] == 0);
      else w = 1;
      chk({phase, " word16_n"}, word16_n, w);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_strobe(int s, logic v);
    case (s)
      S_OE: oe_n = v;
      S_WE: we_n = v;
      S_RD: iord_n = v;
      default: iowr_n = v;
    endcase
  endtask

  task automatic acc(int s, logic c1, logic c2, logic r, int a, int d,
                     output logic [15:0] v, output logic en);
    tick();
    addr = 11'(a); ce1_n = c1; ce2_n = c2; reg_n = r; din = 16'(d);
    tick();
    set_strobe(s, 0);
    repeat (4) tick();
    v = dout; en = dout_en;
    set_strobe(s, 1);
    repeat (4) tick();
    ce1_n = 1; ce2_n = 1; reg_n = 1;
  endtask

  task automatic wr(int s, logic c1, logic c2, logic r, int a, int d);
    logic [15:0] v; logic e;
    acc(s, c1, c2, r, a, d, v, e);
  endtask

  task automatic rdc(string tag, int s, logic c1, logic c2, logic r, int a, logic [15:0] exp);
    logic [15:0] v; logic e;
    acc(s, c1, c2, r, a, 0, v, e);
    chk({tag, " enable"}, e, 1'b1);
    chk(tag, v, exp);
  endtask

  task automatic rd_off(string tag, int s, logic c1, logic c2, logic r, int a);
    logic [15:0] v; logic e;
    acc(s, c1, c2, r, a, 0, v, e);
    chk(tag, e, 1'b0);
  endtask

  task automatic do_reset(bit ide);
    tick();
    rst_n = 0; oe_n = ide ? 1'b0 : 1'b1;
    repeat (3) tick();
    rst_n = 1;
    tick();
    oe_n = 1;
    repeat (2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    phase = "R1";
    chk("R1 idle dout_en", dout_en, 1'b0);
    chk("R1 idle word16_n", word16_n, 1'b1);
    rdc("R1 attr word 0", S_OE, 0, 0, 0, 0, 16'hFF00);
    rdc("R1 common byte 3", S_OE, 0, 1, 1, 3, 16'hFF00);

    phase = "R5";
    wr(S_WE, 0, 1, 0, 4, 'h5A);
    wr(S_WE, 0, 0, 0, 8, 'h1234);
    wr(S_WE, 0, 1, 0, 5, 'h77);
    rdc("R5 attr byte 4", S_OE, 0, 1, 0, 4, 16'hFF5A);
    rdc("R5 attr word 8", S_OE, 0, 0, 0, 8, 16'hFF34);
    rdc("R5 attr odd 5", S_OE, 0, 1, 0, 5, 16'hFFFF);
    rdc("R5 attr odd lane", S_OE, 1, 0, 0, 4, 16'hFFFF);

    phase = "R10";
    rdc("R10 attr unmapped", S_OE, 0, 1, 0, 'h100, 16'hFFFF);
    rdc("R10 common unmapped", S_OE, 0, 1, 1, 9, 16'hFFFF);

    phase = "R2";
    wr(S_WE, 0, 0, 1, 0, 'hBEEF);
    rdc("R2 data word", S_OE, 0, 0, 1, 0, 16'hBEEF);
    rdc("R3 byte 1 after data word", S_OE, 0, 1, 1, 1, 16'hFF00);
    phase = "R3";
    wr(S_WE, 0, 1, 1, 3, 'h33);
    rdc("R3 odd lane 3", S_OE, 1, 0, 1, 2, 16'h33FF);
    rdc("R3 low lane odd A", S_OE, 0, 1, 1, 3, 16'hFF33);
    rdc("R2 word 2", S_OE, 0, 0, 1, 2, 16'h3300);
    wr(S_WE, 1, 0, 1, 4, 'hA500);
    rdc("R2 word 4", S_OE, 0, 0, 1, 4, 16'hA500);
    wr(S_WE, 0, 1, 1, 7, 'h50);
    wr(S_WE, 0, 1, 1, 'hE, 'h06);
    rdc("R2 status alias", S_OE, 0, 1, 1, 'hE, 16'hFF50);
    rdc("R2 devctl read", S_OE, 0, 1, 1, 'hF, 16'hFF06);

    phase = "R6";
    tick();
    addr = 6; ce1_n = 0; ce2_n = 1; reg_n = 1; din = 16'h0011;
    tick(); we_n = 0;
    repeat (3) tick(); din = 16'h0022;
    repeat (2) tick(); we_n = 1;
    repeat (4) tick(); ce1_n = 1;
    rdc("R6 trailing edge data", S_OE, 0, 1, 1, 6, 16'hFF22);

    phase = "R7";
    wr(S_WR, 0, 1, 0, 2, 'h44);
    rdc("R7 iowr ignored", S_OE, 0, 1, 1, 2, 16'hFF00);
    rd_off("R7 iord ignored", S_RD, 0, 1, 0, 2);
    tick(); addr = 0; ce1_n = 0; reg_n = 0; tick(); tick();
    chk("R9 memory mode high", word16_n, 1'b1);
    ce1_n = 1; reg_n = 1;

    phase = "R11";
    tick(); addr = 4; ce1_n = 0; reg_n = 0;
    tick(); oe_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 one edge after fall", dout_en, 1'b0);
    @(negedge clk);
    chk("R11 two edges after fall", dout_en, 1'b1);
    tick(); oe_n = 1; repeat (4) tick(); ce1_n = 1; reg_n = 1;

    phase = "R8";
    wr(S_WE, 0, 1, 0, 'h200, 'h41);
    rdc("R8 config readback", S_OE, 0, 1, 0, 'h200, 16'hFF41);
    wr(S_WR, 0, 1, 0, 2, 'h44);
    rdc("R8 io task read", S_RD, 0, 1, 0, 2, 16'hFF44);
    rd_off("R8 common closed", S_OE, 0, 1, 1, 2);
    wr(S_WR, 0, 1, 0, 7, 'h58);
    rdc("R8 io status alias", S_RD, 0, 1, 0, 'hE, 16'hFF58);
    wr(S_WR, 0, 0, 0, 0, 'h1357);
    rdc("R8 io data word", S_RD, 0, 0, 0, 0, 16'h1357);
    phase = "R9";
    tick(); addr = 1; ce1_n = 0; reg_n = 0; tick(); tick();
    chk("R9 io data select", word16_n, 1'b0);
    addr = 2; tick(); tick();
    chk("R9 io other reg", word16_n, 1'b1);
    ce1_n = 1; reg_n = 1;

    do_reset(1);
    phase = "R4";
    rdc("R1 cleared after reset", S_RD, 0, 1, 1, 3, 16'hFF00);
    wr(S_WR, 0, 1, 1, 0, 'hCAFE);
    rdc("R4 data 16 bit", S_RD, 0, 1, 1, 0, 16'hCAFE);
    tick(); addr = 0; ce1_n = 0; tick(); tick();
    chk("R9 ide data select", word16_n, 1'b0);
    ce1_n = 1;
    wr(S_WR, 0, 1, 1, 'h7FB, 'h9C);
    rdc("R4 high bits ignored", S_RD, 0, 1, 1, 3, 16'hFF9C);
    wr(S_WR, 1, 0, 1, 6, 'h0A);
    rdc("R4 devctl readback", S_RD, 1, 0, 1, 7, 16'hFF0A);
    wr(S_WR, 0, 1, 1, 7, 'h58);
    rdc("R4 alt status", S_RD, 1, 0, 1, 6, 16'hFF58);
    rdc("R4 ce2 unmapped", S_RD, 1, 0, 1, 2, 16'hFFFF);
    rd_off("R4 oe ignored", S_OE, 0, 1, 0, 4);

    do_reset(0);
    phase = "R1";
    rdc("R1 config cleared", S_OE, 0, 1, 0, 'h200, 16'hFF00);
    rd_off("R1 io mode off", S_RD, 0, 1, 0, 2);
    rdc("R1 attr cleared", S_OE, 0, 1, 0, 4, 16'hFF00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule